// File: doc/BRIEF.md
# Multi-Rate Sample Bit Interleaver

This block turns a stream of channel samples into fixed 16-bit storage words. When the sample rate is high, fewer channels can be kept. A mode input picks how the word is shared. In single mode, one word holds one sample of all 16 channels. In dual mode, one word holds two consecutive samples of 8 channels. In quad mode, one word holds four consecutive samples of 4 channels.

In the shared modes the samples are not placed in contiguous fields. Each channel instead owns a small group of adjacent bits, and inside that group the bits are ordered by sample age. Output bit `ch*N + k` holds channel `ch` of the k-th sample of the word, where N is the number of samples per word.

A sample is taken on each cycle where the sample enable is high. A finished word appears on the output together with a one-cycle valid pulse. Changing the mode abandons any word that is only partly built.

Top module: `smpl_interleaver`

## Requirements
- R1: While reset is held, and in the first cycle after it, `word_vld` is 0 and `word_out` is all zeros.
- R2: Mode codes 2'b00 and 2'b11 both select single mode. Each accepted sample is copied whole into `word_out`, and `word_vld` is 1 in the cycle after the clock edge that accepts it.
- R3: Mode code 2'b01 selects dual mode. Output bit 2*ch+k equals input channel ch (0..7) of the k-th accepted sample (k = 0, 1) of the word.
- R4: Mode code 2'b10 selects quad mode. Output bit 4*ch+k equals input channel ch (0..3) of the k-th accepted sample (k = 0..3) of the word.
- R5: `word_vld` is high for exactly one cycle per completed word: the cycle after the edge that accepts the last sample of that word. It is low in every other cycle.
- R6: `word_out` keeps its value from one completed word until the next completed word.
- R7: A cycle with `smp_en` low has no effect on the word being built or on the outputs, whatever `smp_in` carries in that cycle.
- R8: If `mode` differs from its value in the previous cycle, any partly built word is discarded. A sample accepted in that same cycle becomes sample 0 of a new word in the new mode.
- R9: In dual mode, input channels 8..15 are ignored. In quad mode, input channels 4..15 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Packing select: 00/11 single, 01 dual, 10 quad |
| smp_en | input | 1 | Accept `smp_in` on this edge |
| smp_in | input | 16 | One sample of all channels |
| word_out | output | 16 | Last completed storage word |
| word_vld | output | 1 | One-cycle pulse for a new word |

## Verification
The bench sweeps all four mode codes with back-to-back samples and with gaps. Upper input channels carry noise during these sweeps, so a design that packed fields contiguously instead of channel-major, or that let an unused channel leak in, produces a wrong word. Idle cycles drive random data with the enable low. A design that sampled without the enable, or that refreshed the output between words, is caught there.

Mode switches are applied in the middle of a word, both in a cycle with a sample and in an idle cycle. A design that kept stale sub-samples or did not restart its counter would misplace bits or pulse valid at the wrong time. Valid is checked low after every sample that does not finish a word, so an early or doubled pulse shows up.

// File: rtl/pk_pack_pkg.sv
package pk_pack_pkg;
  typedef enum logic [1:0] {
    PK_X1  = 2'd0,
    PK_X2  = 2'd1,
    PK_X4  = 2'd2,
    PK_X1B = 2'd3
  } pk_mode_e;

  // samples carried by one word in a given mode
  function automatic int pk_spw(input logic [1:0] m);
    case (m)
      PK_X2:   return 2;
      PK_X4:   return 4;
      default: return 1;
    endcase
  endfunction

  // index of the final sub-sample of a word
  function automatic logic [1:0] pk_last_idx(input logic [1:0] m);
    return 2'(pk_spw(m) - 1);
  endfunction
endpackage

// File: rtl/pk_mode_trk.sv
module pk_mode_trk (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  output logic [1:0] mode_q,
  output logic       mode_chg
);
  always_ff @(posedge clk) begin
    if (!rst_n) mode_q <= 2'd0;
    else        mode_q <= mode;
  end

  assign mode_chg = (mode != mode_q);
endmodule

// File: rtl/pk_subcnt.sv
module pk_subcnt
  import pk_pack_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       mode_chg,
  input  logic       smp_en,
  output logic [1:0] cnt_q,
  output logic [1:0] eff_cnt,
  output logic       word_done
);
  logic [1:0] cnt_d;

  assign eff_cnt   = mode_chg ? 2'd0 : cnt_q;
  assign word_done = smp_en && (eff_cnt == pk_last_idx(mode));

  always_comb begin
    cnt_d = eff_cnt;
    if (smp_en) cnt_d = word_done ? 2'd0 : eff_cnt + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= 2'd0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/pk_lane_merge.sv
module pk_lane_merge
  import pk_pack_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic [1:0]        mode,
  input  logic [1:0]        eff_cnt,
  input  logic [WORD_W-1:0] smp_in,
  input  logic [WORD_W-1:0] acc_in,
  output logic [WORD_W-1:0] acc_out
);
  for (genvar b = 0; b < WORD_W; b++) begin : g_bit
    localparam int K2 = b % 2;
    localparam int C2 = b / 2;
    localparam int K4 = b % 4;
    localparam int C4 = b / 4;
    always_comb begin
      case (mode)
        PK_X2:   acc_out[b] = (eff_cnt == 2'(K2)) ? smp_in[C2] : acc_in[b];
        PK_X4:   acc_out[b] = (eff_cnt == 2'(K4)) ? smp_in[C4] : acc_in[b];
        default: acc_out[b] = smp_in[b];
      endcase
    end
  end
endmodule

// File: rtl/smpl_interleaver.sv
module smpl_interleaver
  import pk_pack_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              smp_en,
  input  logic [WORD_W-1:0] smp_in,
  output logic [WORD_W-1:0] word_out,
  output logic              word_vld
);
  logic [1:0]        mode_q;
  logic              mode_chg;
  logic [1:0]        cnt_q;
  logic [1:0]        eff_cnt;
  logic              word_done;
  logic [WORD_W-1:0] acc_q;
  logic [WORD_W-1:0] acc_base;
  logic [WORD_W-1:0] acc_merged;

  pk_mode_trk u_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode),
    .mode_q   (mode_q),
    .mode_chg (mode_chg)
  );

  pk_subcnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .mode_chg  (mode_chg),
    .smp_en    (smp_en),
    .cnt_q     (cnt_q),
    .eff_cnt   (eff_cnt),
    .word_done (word_done)
  );

  // a mode switch drops whatever was gathered so far
  assign acc_base = mode_chg ? '0 : acc_q;

  pk_lane_merge #(.WORD_W(WORD_W)) u_merge (
    .mode    (mode),
    .eff_cnt (eff_cnt),
    .smp_in  (smp_in),
    .acc_in  (acc_base),
    .acc_out (acc_merged)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q    <= '0;
      word_out <= '0;
      word_vld <= 1'b0;
    end else begin
      word_vld <= word_done;
      if (word_done) begin
        word_out <= acc_merged;
        acc_q    <= '0;
      end else if (smp_en) begin
        acc_q <= acc_merged;
      end else begin
        acc_q <= acc_base;
      end
    end
  end
endmodule

// File: rtl/pk_pack_chk.sv
module pk_pack_chk
  import pk_pack_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        mode,
  input logic              smp_en,
  input logic [1:0]        mode_q,
  input logic              mode_chg,
  input logic [1:0]        cnt_q,
  input logic              word_done,
  input logic [WORD_W-1:0] word_out,
  input logic              word_vld
);
  AST_VLD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    word_done |=> word_vld);  // R5
  AST_NO_STRAY_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> !word_vld);  // R5
  AST_SINGLE_EVERY: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && (mode == PK_X1 || mode == PK_X1B)) |=> word_vld);  // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_done |=> $stable(word_out));  // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) < pk_spw(mode_q));  // R4
  AST_CHG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_chg && !smp_en) |=> (cnt_q == 2'd0));  // R8
  AST_IDLE_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> !word_vld);  // R7
endmodule

bind smpl_interleaver pk_pack_chk #(.WORD_W(WORD_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode      (mode),
  .smp_en    (smp_en),
  .mode_q    (mode_q),
  .mode_chg  (mode_chg),
  .cnt_q     (cnt_q),
  .word_done (word_done),
  .word_out  (word_out),
  .word_vld  (word_vld)
);

// File: tb/sim_smpl_interleaver.sv
`timescale 1ns/1ps
module sim_smpl_interleaver;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        smp_en = 1'b0;
  logic [15:0] smp_in = '0;
  logic [15:0] word_out;
  logic        word_vld;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] last_word = '0;

  always #2.5 clk = ~clk;

  smpl_interleaver u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .smp_en(smp_en),
    .smp_in(smp_in), .word_out(word_out), .word_vld(word_vld)
  );

  // expected word: walk samples then channels, place at ch*n+k
  function automatic logic [15:0] exp_word(input logic [1:0] m,
      input logic [15:0] s0, input logic [15:0] s1,
      input logic [15:0] s2, input logic [15:0] s3);
    logic [15:0] s [4];
    logic [15:0] r;
    int n;
    s[0] = s0; s[1] = s1; s[2] = s2; s[3] = s3;
    n = (m == 2'd1) ? 2 : (m == 2'd2) ? 4 : 1;
    r = '0;
    for (int k = 0; k < n; k++)
      for (int c = 0; c < 16 / n; c++)
        r[c * n + k] = s[k][c];
    return r;
  endfunction

  function automatic logic [15:0] pat(input int a, input int b);
    return 16'((a * 40503 + b * 9973 + 12345) ^ (a << 7) ^ (b << 3));
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one accepted sample at this negedge, look at the next negedge
  task automatic put(input logic [1:0] m, input logic [15:0] d, input bit fin,
                     input logic [15:0] expw, input string req);
    mode = m; smp_en = 1'b1; smp_in = d;
    @(negedge clk);
    smp_en = 1'b0;
    chk(word_vld == fin, {req, " valid"}, 16'(word_vld), 16'(fin));
    if (fin) begin
      chk(word_out == expw, {req, " word"}, word_out, expw);
      last_word = word_out;
    end else begin
      chk(word_out == last_word, "R6 hold", word_out, last_word);
    end
  endtask

  // cycle with enable low and noise on the data
  task automatic idle(input logic [1:0] m, input logic [15:0] noise);
    mode = m; smp_en = 1'b0; smp_in = noise;
    @(negedge clk);
    chk(word_vld == 1'b0, "R7 idle valid", 16'(word_vld), 16'h0);
    chk(word_out == last_word, "R7 idle word", word_out, last_word);
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] s [4];
    repeat (3) @(negedge clk);
    chk(word_vld == 1'b0, "R1 vld in reset", 16'(word_vld), 16'h0);
    chk(word_out == 16'h0, "R1 word in reset", word_out, 16'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_vld == 1'b0 && word_out == 16'h0, "R1 after reset", word_out, 16'h0);

    // sweep every mode code, several words, gaps on odd words (R2 R3 R4 R9 R5)
    for (int m = 0; m < 4; m++) begin
      int n;
      n = (m == 1) ? 2 : (m == 2) ? 4 : 1;
      idle(2'(m), 16'hA5A5);
      for (int w = 0; w < 8; w++) begin
        for (int k = 0; k < n; k++) s[k] = pat(m * 8 + w, k);
        for (int k = n; k < 4; k++) s[k] = '0;
        for (int k = 0; k < n; k++) begin
          put(2'(m), s[k], k == n - 1, exp_word(2'(m), s[0], s[1], s[2], s[3]),
              (m == 1) ? "R3 R9 dual" : (m == 2) ? "R4 R9 quad" : "R2 single");
          if (w % 2 == 1) idle(2'(m), pat(w, k + 50));
        end
      end
    end

    // R9: only upper channels toggle, word must be zero
    put(2'd2, 16'hFFF0, 0, 16'h0, "R9 quad");
    put(2'd2, 16'hFFF0, 0, 16'h0, "R9 quad");
    put(2'd2, 16'hFFF0, 0, 16'h0, "R9 quad");
    put(2'd2, 16'hFFF0, 1, 16'h0000, "R9 quad upper ignored");
    put(2'd1, 16'hFF00, 0, 16'h0, "R9 dual");
    put(2'd1, 16'hFF00, 1, 16'h0000, "R9 dual upper ignored");

    // R8: switch with a sample in the change cycle
    put(2'd2, 16'h000F, 0, 16'h0, "R8 partial");
    put(2'd2, 16'h0005, 0, 16'h0, "R8 partial");
    put(2'd1, 16'h00C3, 0, 16'h0, "R8 switch sample");
    put(2'd1, 16'h003C, 1, exp_word(2'd1, 16'h00C3, 16'h003C, 0, 0), "R8 new dual word");

    // R8: switch during an idle cycle
    put(2'd1, 16'h00FF, 0, 16'h0, "R8 partial dual");
    idle(2'd2, 16'hFFFF);
    for (int k = 0; k < 4; k++) s[k] = pat(99, k);
    for (int k = 0; k < 4; k++)
      put(2'd2, s[k], k == 3, exp_word(2'd2, s[0], s[1], s[2], s[3]), "R8 new quad word");

    // R8: dual to single mid-word gives a word at once
    put(2'd1, 16'h1234, 0, 16'h0, "R8 partial dual");
    put(2'd3, 16'hBEEF, 1, 16'hBEEF, "R8 R2 switch to single");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule